// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a register-programmed master for the two-wire serial management bus (MDC clock, bidirectional MDIO data). Software first writes a control register. That register selects the MDC divisor and turns the preamble on or off. Software then writes a 32-bit command word that already holds a complete Clause-22 frame. This means software builds the start pattern, opcode, PHY address, register address, turnaround and write data itself. The controller shifts the word out as it stands.

The controller derives MDC from the system clock. If the preamble is enabled, it sends 32 ones first. It then shifts the command word out MSB-first, changing MDIO only while MDC falls. In a read frame it releases the data line from the turnaround bits onward. It samples the PHY's 16 reply bits on rising MDC edges and places them in the low half of the data register. A read-only completion flag in the control register tells software when a frame has ended.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After synchronous reset, mdc is 0, mdio_oe is 0, and both registers read back as zero.
- R2: Each MDC half-period lasts (divisor + 1) system clocks, where the divisor is control bits 3:0. A divisor of 0 behaves as 1. MDC is low in the first half of every bit and high in the second half.
- R3: When control bit 7 is 1, 32 one-bits go out before command bit 31. When control bit 7 is 0, no preamble is sent.
- R4: Command bits go out in order from bit 31 down to bit 0. mdio_out changes only on cycles where MDC falls.
- R5: A frame is a read when command bit 29 is 1 and bit 28 is 0. In a read frame, mdio_oe is 0 from command bit 17 through bit 0. On each rising MDC edge of bits 15..0, mdio_in is shifted into data register bits 15:0, so the PHY's bit 15 ends up in bit 15. Data register bits 31:16 keep the command.
- R6: In a write frame (any frame that is not a read), mdio_oe stays 1 for every bit of the frame.
- R7: Completion flag control bit 8 goes to 0 on the clock after a data register write starts a frame. It goes to 1 one clock after the final MDC high half ends.
- R8: A write to the data register while a frame is in progress is ignored. The frame being sent and the stored command do not change.
- R9: A control register write updates only the divisor and preamble-enable fields. All other control bits read as 0, except bit 8, which software cannot write. Writing 0 clears the divisor and turns off the preamble.
- R10: bus_rdata is combinational. bus_addr 0 selects the control register and bus_addr 1 selects the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Register select: 0 control, 1 data |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data driven onto the MDIO line |
| mdio_oe | output | 1 | Output enable for the MDIO driver |
| mdio_in | input | 1 | Sampled MDIO line |

## Verification
The embedded properties assume that software does not change the divisor while a frame is running. They also assume that mdio_in matters only while the controller has released the line. Under these assumptions, the half-period counter always wraps at a steady limit. The bench keeps to both rules: it writes the control register only while the controller is idle. Its PHY model drives mdio_in only after a falling MDC edge in the released part of a read frame, and holds it at 1 otherwise.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int CMD_W        = 32;
    localparam int PRE_BITS     = 32;
    localparam int DIV_W        = 4;
    localparam int RD_BITS      = 16;
    localparam int CTL_PRE_POS  = 7;
    localparam int CTL_DONE_POS = 8;
    localparam int CMD_RD_POS   = 29;
    localparam int CMD_WR_POS   = 28;
    localparam int CMD_TA_POS   = 17;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_DATA = 1'b1;

    typedef struct packed {
        logic             pre_en;
        logic [DIV_W-1:0] div;
    } mdio_ctrl_t;

    function automatic logic [CMD_W-1:0] ctrl_word(mdio_ctrl_t c, logic done);
        logic [CMD_W-1:0] w;
        w               = '0;
        w[DIV_W-1:0]    = c.div;
        w[CTL_PRE_POS]  = c.pre_en;
        w[CTL_DONE_POS] = done;
        return w;
    endfunction

    function automatic logic is_read_cmd(logic [CMD_W-1:0] c);
        return c[CMD_RD_POS] & ~c[CMD_WR_POS];
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DW = mdio_mgmt_pkg::DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          half_tick
);

    logic [DW-1:0] cnt_q;
    logic [DW-1:0] lim;

    assign lim       = (div == '0) ? DW'(1) : div;
    assign half_tick = run && (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (cnt_q >= lim)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DW'(1);
    end

    AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        half_tick |=> (cnt_q == '0)); // R2

    AST_COUNT_IN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $stable(div)) |-> (cnt_q <= lim)); // R2

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int CMD_BITS = CMD_W,
    parameter int PRE_LEN  = PRE_BITS,
    parameter int CAP_BITS = RD_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                pre_en,
    input  logic [CMD_BITS-1:0] cmd,
    input  logic                half_tick,
    input  logic                mdio_in,
    output logic                busy,
    output logic                mdc,
    output logic                mdio_out,
    output logic                mdio_oe,
    output logic                cap_valid,
    output logic                cap_bit,
    output logic                frame_done
);

    localparam int CNT_W = $clog2(CMD_BITS + PRE_LEN + 1);

    logic [CNT_W-1:0]    left_q;
    logic [CMD_BITS-1:0] sh_q;
    logic                busy_q, mdc_q, rd_q;
    logic                in_cmd, rise, fall, released;

    assign in_cmd   = (left_q <= CNT_W'(CMD_BITS));
    assign rise     = busy_q && half_tick && !mdc_q;
    assign fall     = busy_q && half_tick &&  mdc_q;
    assign released = rd_q && in_cmd && (left_q <= CNT_W'(CMD_TA_POS + 1));

    assign busy       = busy_q;
    assign mdc        = mdc_q;
    assign mdio_out   = (busy_q && in_cmd) ? sh_q[CMD_BITS-1] : 1'b1;
    assign mdio_oe    = busy_q && !released;
    assign cap_valid  = rise && rd_q && in_cmd && (left_q <= CNT_W'(CAP_BITS));
    assign cap_bit    = mdio_in;
    assign frame_done = fall && (left_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            mdc_q  <= 1'b0;
            rd_q   <= 1'b0;
            left_q <= '0;
            sh_q   <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            mdc_q  <= 1'b0;
            rd_q   <= is_read_cmd(cmd);
            sh_q   <= cmd;
            left_q <= pre_en ? CNT_W'(CMD_BITS + PRE_LEN) : CNT_W'(CMD_BITS);
        end else if (busy_q) begin
            if (rise)
                mdc_q <= 1'b1;
            if (fall) begin
                mdc_q  <= 1'b0;
                left_q <= left_q - CNT_W'(1);
                if (in_cmd)
                    sh_q <= sh_q << 1;
                if (left_q == CNT_W'(1))
                    busy_q <= 1'b0;
            end
        end
    end

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !mdc_q); // R1

    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q) && !$fell(mdc_q)) |-> $stable(mdio_out)); // R4

    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !rd_q) |-> mdio_oe); // R6

    AST_CAPTURE_RISE: assert property (@(posedge clk) disable iff (rst)
        cap_valid |=> $rose(mdc_q)); // R5

    AST_CAPTURE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        cap_valid |-> !mdio_oe); // R5

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
    import mdio_mgmt_pkg::*;
#(
    parameter int WORD_W   = CMD_W,
    parameter int CAP_BITS = RD_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              frame_done,
    input  logic              cap_valid,
    input  logic              cap_bit,
    output logic              start,
    output mdio_ctrl_t        ctrl,
    output logic [WORD_W-1:0] cmd
);

    mdio_ctrl_t        ctrl_q;
    logic [WORD_W-1:0] data_q;
    logic              done_q;

    assign start     = bus_wr && (bus_addr == ADDR_DATA) && !busy;
    assign ctrl      = ctrl_q;
    assign cmd       = bus_wdata;
    assign bus_rdata = (bus_addr == ADDR_CTRL) ? ctrl_word(ctrl_q, done_q) : data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            data_q <= '0;
            done_q <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == ADDR_CTRL) begin
                ctrl_q.pre_en <= bus_wdata[CTL_PRE_POS];
                ctrl_q.div    <= bus_wdata[DIV_W-1:0];
            end
            if (start) begin
                data_q <= bus_wdata;
                done_q <= 1'b0;
            end else if (cap_valid) begin
                data_q[CAP_BITS-1:0] <= {data_q[CAP_BITS-2:0], cap_bit};
            end
            if (frame_done)
                done_q <= 1'b1;
        end
    end

    AST_DONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy); // R7

    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
        start |=> !done_q); // R7

    AST_CMD_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(data_q[WORD_W-1:CAP_BITS])); // R8

endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int FRAME_BITS    = CMD_W,
    parameter int PREAMBLE_BITS = PRE_BITS,
    parameter int READ_BITS     = RD_BITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_addr,
    input  logic                  bus_wr,
    input  logic [FRAME_BITS-1:0] bus_wdata,
    output logic [FRAME_BITS-1:0] bus_rdata,
    output logic                  mdc,
    output logic                  mdio_out,
    output logic                  mdio_oe,
    input  logic                  mdio_in
);

    mdio_ctrl_t            ctrl;
    logic [FRAME_BITS-1:0] cmd;
    logic start, busy, half_tick, cap_valid, cap_bit, frame_done;

    mdio_reg_bank #(
        .WORD_W   (FRAME_BITS),
        .CAP_BITS (READ_BITS)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .busy       (busy),
        .frame_done (frame_done),
        .cap_valid  (cap_valid),
        .cap_bit    (cap_bit),
        .start      (start),
        .ctrl       (ctrl),
        .cmd        (cmd)
    );

    mdio_clk_div #(
        .DW (DIV_W)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .div       (ctrl.div),
        .half_tick (half_tick)
    );

    mdio_frame_engine #(
        .CMD_BITS (FRAME_BITS),
        .PRE_LEN  (PREAMBLE_BITS),
        .CAP_BITS (READ_BITS)
    ) u_engine (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .pre_en     (ctrl.pre_en),
        .cmd        (cmd),
        .half_tick  (half_tick),
        .mdio_in    (mdio_in),
        .busy       (busy),
        .mdc        (mdc),
        .mdio_out   (mdio_out),
        .mdio_oe    (mdio_oe),
        .cap_valid  (cap_valid),
        .cap_bit    (cap_bit),
        .frame_done (frame_done)
    );

endmodule

// File: tb/mdio_frame_ctrl_tb.sv
module mdio_frame_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_addr = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_frame_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    // counters of the main sequence and of the per-clock comparison
    int n_run = 0, n_fail = 0, c_run = 0, c_fail = 0;

    // behavioural reference model and PHY model, advanced at every falling clk
    bit          m_valid = 0, m_busy = 0, m_done = 0, m_pre = 0, m_rd = 0;
    logic [3:0]  m_div = '0;
    logic [31:0] m_cmd = '0;
    int          m_t = 0, m_len = 0, m_h = 2, m_np = 0;
    int          e_p, e_k, e_idx;
    bit          e_mdc, e_out, e_oe, old_busy;
    logic [15:0] phy_rsp = '0;
    bit          prev_mdc = 0;
    int          phy_rises = 0;
    logic [63:0] phy_bits = '0;

    always @(negedge clk) begin
        if (m_valid && !rst) begin
            e_mdc = 0; e_out = 1; e_oe = 0;
            if (m_busy) begin
                e_p   = 2 * m_h;
                e_k   = m_t / e_p;
                e_idx = 31 - (e_k - m_np);
                e_mdc = (m_t % e_p) >= m_h;
                e_out = (e_k < m_np) ? 1'b1 : m_cmd[e_idx];
                e_oe  = !(m_rd && e_k >= m_np && e_idx <= 17);
            end
            c_run++;
            if (mdc !== e_mdc) begin
                c_fail++;
                $display("FAIL R2 mdc t=%0d act=%b exp=%b", m_t, mdc, e_mdc);
            end
            if (mdio_oe !== e_oe) begin
                c_fail++;
                $display("FAIL %s oe t=%0d act=%b exp=%b", m_rd ? "R5" : "R6", m_t, mdio_oe, e_oe);
            end
            if (e_oe && mdio_out !== e_out) begin
                c_fail++;
                $display("FAIL R4 mdio_out t=%0d act=%b exp=%b", m_t, mdio_out, e_out);
            end
            if (!bus_wr && bus_addr == 1'b0 &&
                (bus_rdata[8] !== m_done || bus_rdata[7] !== m_pre || bus_rdata[3:0] !== m_div)) begin
                c_fail++;
                $display("FAIL R7 ctrl readback act=%h exp done=%b pre=%b div=%h",
                         bus_rdata, m_done, m_pre, m_div);
            end
            // PHY side
            if (mdc && !prev_mdc) begin
                phy_rises++;
                phy_bits = {phy_bits[62:0], mdio_oe ? mdio_out : 1'b0};
            end
            if (!mdc && prev_mdc) begin
                e_idx = 31 - (phy_rises - m_np);
                if (m_rd && phy_rises >= m_np && e_idx <= 15)
                    mdio_in = phy_rsp[e_idx];
                else if (m_rd && phy_rises >= m_np && e_idx == 16)
                    mdio_in = 1'b0;
                else
                    mdio_in = 1'b1;
            end
        end
        prev_mdc = mdc;
        // advance the model to the state after the coming rising edge
        if (rst) begin
            m_valid = 1; m_busy = 0; m_done = 0; m_pre = 0; m_div = '0;
            m_t = 0; mdio_in = 1'b1;
        end else begin
            old_busy = m_busy;
            if (m_busy) begin
                m_t++;
                if (m_t == m_len) begin
                    m_busy = 0;
                    m_done = 1;
                    mdio_in = 1'b1;
                end
            end
            if (bus_wr && bus_addr == 1'b0) begin
                m_pre = bus_wdata[7];
                m_div = bus_wdata[3:0];
            end else if (bus_wr && bus_addr == 1'b1 && !old_busy) begin
                m_busy = 1; m_done = 0; m_t = 0; m_cmd = bus_wdata;
                m_rd  = bus_wdata[29] && !bus_wdata[28];
                m_h   = ((m_div == 0) ? 1 : int'(m_div)) + 1;
                m_np  = m_pre ? 32 : 0;
                m_len = (m_np + 32) * 2 * m_h;
                phy_rises = 0; phy_bits = '0; mdio_in = 1'b1;
            end
        end
    end

    function automatic logic [31:0] mk_cmd(bit rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
        return (32'h1 << 30) | (rd ? (32'h1 << 29) : (32'h1 << 28)) |
               (32'(phy) << 22) | (32'(rg) << 18) | (32'h1 << 17) | 32'(d);
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic drive(bit a, logic [31:0] d, bit w);
        @(posedge clk);
        #2;
        bus_addr = a; bus_wdata = d; bus_wr = w;
    endtask

    task automatic reg_wr(bit a, logic [31:0] d);
        drive(a, d, 1);
        drive(0, '0, 0);
    endtask

    task automatic reg_rd(bit a, output logic [31:0] v);
        drive(a, '0, 0);
        @(negedge clk);
        v = bus_rdata;
        drive(0, '0, 0);
    endtask

    task automatic wait_idle();
        bit idle = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!m_busy) begin idle = 1; break; end
        end
        check(idle, "R7 frame end", 64'(idle), 64'd1);
    endtask

    task automatic run_frame(bit pre, logic [3:0] div, logic [31:0] c, logic [15:0] rsp);
        logic [31:0] v;
        bit rd;
        rd = c[29] && !c[28];
        reg_wr(0, (32'(pre) << 7) | 32'(div));
        phy_rsp = rsp;
        reg_wr(1, c);
        wait_idle();
        check(phy_rises == (pre ? 64 : 32), "R2 mdc cycles", 64'(phy_rises), pre ? 64'd64 : 64'd32);
        if (pre)
            check(phy_bits[63:32] == '1, "R3 preamble", phy_bits[63:32], 64'hFFFF_FFFF);
        else
            check(phy_rises == 32, "R3 no preamble", 64'(phy_rises), 64'd32);
        if (rd) begin
            check(phy_bits[31:18] == c[31:18], "R4 read header", phy_bits[31:18], c[31:18]);
            reg_rd(1, v);
            check(v == {c[31:16], rsp}, "R5 read data", v, {c[31:16], rsp});
        end else begin
            check(phy_bits[31:0] == c, "R6 write frame", phy_bits[31:0], c);
            reg_rd(1, v);
            check(v == c, "R10 data readback", v, c);
        end
        reg_rd(0, v);
        check(v[8] == 1'b1, "R7 done set", v[8], 1'b1);
    endtask

    task automatic main_seq();
        logic [31:0] v, ca;
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        // R1 reset state
        @(negedge clk);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins", {mdc, mdio_oe}, 0);
        reg_rd(0, v); check(v == 0, "R1 ctrl", v, 0);
        reg_rd(1, v); check(v == 0, "R1 data", v, 0);
        // R3/R6 write with preamble, divisor 2
        run_frame(1, 4'd2, mk_cmd(0, 5'h1D, 5'h01, 16'hC0C0), 16'h0);
        // R5 read with preamble
        run_frame(1, 4'd2, mk_cmd(1, 5'h1F, 5'h01, 16'h0), 16'hA5C3);
        // R2 divisor 0 behaves as 1, no preamble
        run_frame(0, 4'd0, mk_cmd(0, 5'h03, 5'h1E, 16'h5A17), 16'h0);
        // R5 read without preamble, divisor 5
        run_frame(0, 4'd5, mk_cmd(1, 5'h12, 5'h09, 16'h0), 16'h3C96);
        // R8 write while busy is ignored
        ca = mk_cmd(0, 5'h07, 5'h04, 16'h1234);
        reg_wr(0, 32'h0000_0082);
        reg_wr(1, ca);
        repeat (30) @(posedge clk);
        reg_wr(1, mk_cmd(0, 5'h18, 5'h1B, 16'hBEEF));
        reg_rd(1, v);
        check(v == ca, "R8 cmd kept", v, ca);
        wait_idle();
        check(phy_bits[31:0] == ca, "R8 frame kept", phy_bits[31:0], ca);
        // R9 field masking and read-only done
        reg_wr(0, 32'h0000_00FF);
        reg_rd(0, v);
        check(v == 32'h0000_018F, "R9 ctrl fields", v, 32'h0000_018F);
        reg_wr(0, 32'h0000_0000);
        reg_rd(0, v);
        check(v == 32'h0000_0100, "R9 zero write", v, 32'h0000_0100);
        // R10 bus mux: control and data selected by address
        reg_rd(1, v);
        check(v == ca, "R10 data select", v, ca);
        repeat (5) @(posedge clk);
    endtask

    initial begin
        bit wd = 0;
        fork
            main_seq();
            begin
                repeat (WD_CYCLES) @(posedge clk);
                wd = 1;
            end
        join_any
        disable fork;
        if (wd) begin
            n_run++; n_fail++;
            $display("FAIL watchdog act=expired exp=finished");
        end
        $display("[TB] %0d tests run, %0d failed", n_run + c_run, n_fail + c_fail);
        $finish;
    end

endmodule